// File: doc/BRIEF.md
# PCI Target Burst Address Sequencer

This block is the sequencing core on the target side of a simplified PCI interface. It watches FRAME# for the start of a transaction. In the address clock it latches the address from the AD lines and reads the two low lines as a burst ordering code. It also checks which of its regions the address falls in.

The block claims an address that hits either of two regions:
- a small internal register region, which never bursts;
- a general window, which may burst.

After the claim it produces the dword address of each data phase. The address advances only on clocks where a data phase completes. It moves linearly, or wraps inside an aligned cache line.

A local `localReady` signal tells the block when read data is valid, and TRDY# follows it. The block disconnects after the first data phase with STOP# in two cases: an access to the register region, and an access that carries a reserved ordering code. PCI control signals are active low, and a value of 0 on a port ending in `N` means asserted.

Top module: `pciTgtSeq`

## Requirements
- R1: During and right after reset, `trdyN`, `devselN` and `stopN` are all 1 (deasserted).
- R2: A transaction starts on a clock where `frameN` is 0 and the block is idle. If the latched address hits the register region (`REG_BASE`/`REG_MASK`) or the window region (`WIN_BASE`/`WIN_MASK`), `devselN` goes to 0 from the next clock and stays 0 until the transaction ends. For any other address, `devselN` stays 1 for the whole transaction.
- R3: While the block is claiming and still accepting phases, `trdyN` is 0 exactly when `localReady` is 1. A data phase completes on a clock where `irdyN` and `trdyN` are both 0.
- R4: With ordering code `adIn[1:0]`=00 (linear) in the window, `phaseAddr` rises by 4 after each completed data phase, and may cross cache-line boundaries.
- R5: With ordering code 10 (wrap) in the window, the dword index `phaseAddr[3:2]` rises by 1 modulo 4 after each completed phase. Bits 31:4 never change, so the address stays in its aligned 4-dword line.
- R6: On clocks where no data phase completes (wait states), `phaseAddr` holds its value.
- R7: An access to the register region asserts `stopN`=0 together with `devselN` from the first data phase. After that phase completes, `trdyN` stays 1 while `stopN` and `devselN` stay 0 until `frameN` returns to 1. On the following clock, all three are released.
- R8: Reserved ordering codes 01 and 11 in the window behave like a register region access: one data phase, then a disconnect with STOP#.
- R9: When a data phase completes with `frameN`=1, it is the last phase. On the next clock, `trdyN`, `devselN` and `stopN` are all 1.
- R10: The first data phase presents `phaseAddr` equal to the latched address with bits 1:0 forced to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameN | input | 1 | FRAME# from the initiator |
| irdyN | input | 1 | IRDY# from the initiator |
| adIn | input | 32 | AD lines as sampled; address and ordering code in the address clock |
| localReady | input | 1 | Local side has valid read data for the current phase |
| trdyN | output | 1 | TRDY# to the initiator |
| devselN | output | 1 | DEVSEL# to the initiator |
| stopN | output | 1 | STOP# to the initiator |
| phaseAddr | output | 32 | Dword address of the current data phase |

## Verification
The hardest case to reach from the ports is a disconnect where the initiator still wants more data. FRAME# must still be 0 when the single allowed phase completes, and it must only be released later while STOP# is held. The sweep reaches this case with register region and reserved-code accesses that request up to five phases, and it checks the drain clock and the release clock separately.

Wait states come from a rotating `localReady` pattern, so phases complete at irregular clocks. Start offsets cover every dword of a line, so the wrap point and linear line crossings land in every position.

// File: rtl/pciTgtSeqPkg.sv
package pciTgtSeqPkg;
  typedef enum logic [1:0] {
    ORD_LINEAR = 2'b00,
    ORD_RSV1   = 2'b01,
    ORD_WRAP   = 2'b10,
    ORD_RSV3   = 2'b11
  } burstOrder_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DATA,
    ST_DRAIN,
    ST_BUSY
  } tgtState_t;

  typedef struct packed {
    logic capture;
    logic advance;
  } tgtStrobe_t;
endpackage

// File: rtl/pciTgtSeqPath.sv
module pciTgtSeqPath
  import pciTgtSeqPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LINE_WORDS = 4,
  parameter logic [ADDR_W-1:0] REG_BASE = 32'h0000_1000,
  parameter logic [ADDR_W-1:0] REG_MASK = 32'hFFFF_FF00,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'h0010_0000,
  parameter logic [ADDR_W-1:0] WIN_MASK = 32'hFFF0_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] adIn,
  input  tgtStrobe_t        strobes,
  output logic              addrHit,
  output logic              singleOnly,
  output logic [ADDR_W-1:0] phaseAddr
);
  localparam int LINE_BITS = $clog2(LINE_WORDS);
  localparam int IDX_LO = 2;
  localparam int IDX_HI = LINE_BITS + 1;

  logic [ADDR_W-1:0] curAddr;
  burstOrder_t       curOrder;
  logic              curRegion;
  logic              regHit;
  logic              winHit;
  logic [ADDR_W-1:0] nextAddr;
  logic [LINE_BITS-1:0] nextIdx;

  always_comb begin
    regHit  = (adIn & REG_MASK) == REG_BASE;
    winHit  = (adIn & WIN_MASK) == WIN_BASE;
    addrHit = regHit | winHit;
  end

  always_comb begin
    nextIdx = curAddr[IDX_HI:IDX_LO] + 1'b1;
    nextAddr = curAddr + ADDR_W'(4);
    if (curOrder == ORD_WRAP) begin
      nextAddr = curAddr;
      nextAddr[IDX_HI:IDX_LO] = nextIdx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr   <= '0;
      curOrder  <= ORD_LINEAR;
      curRegion <= 1'b0;
    end else if (strobes.capture) begin
      curAddr   <= {adIn[ADDR_W-1:2], 2'b00};
      curOrder  <= burstOrder_t'(adIn[1:0]);
      curRegion <= regHit;
    end else if (strobes.advance) begin
      curAddr <= nextAddr;
    end
  end

  assign singleOnly = curRegion | (curOrder == ORD_RSV1) | (curOrder == ORD_RSV3);
  assign phaseAddr  = curAddr;

  // R4
  linear_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.advance && !strobes.capture && curOrder == ORD_LINEAR)
      |=> phaseAddr == $past(phaseAddr) + ADDR_W'(4));

  // R5
  wrap_in_line_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.advance && !strobes.capture && curOrder == ORD_WRAP)
      |=> phaseAddr[ADDR_W-1:IDX_HI+1] == $past(phaseAddr[ADDR_W-1:IDX_HI+1]));

  // R6
  hold_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.advance && !strobes.capture) |=> $stable(phaseAddr));

  // R10
  first_aligned_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |=> phaseAddr[1:0] == 2'b00);
endmodule

// File: rtl/pciTgtSeqCtrl.sv
module pciTgtSeqCtrl
  import pciTgtSeqPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameN,
  input  logic       irdyN,
  input  logic       localReady,
  input  logic       addrHit,
  input  logic       singleOnly,
  output tgtStrobe_t strobes,
  output logic       trdyN,
  output logic       devselN,
  output logic       stopN
);
  tgtState_t state;
  tgtState_t stateNext;
  logic      phaseDone;

  assign phaseDone = (state == ST_DATA) && !irdyN && localReady;

  always_comb begin
    stateNext       = state;
    strobes.capture = 1'b0;
    strobes.advance = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (!frameN) begin
          strobes.capture = 1'b1;
          stateNext = addrHit ? ST_DATA : ST_BUSY;
        end
      end
      ST_DATA: begin
        if (phaseDone) begin
          strobes.advance = 1'b1;
          if (frameN)          stateNext = ST_IDLE;
          else if (singleOnly) stateNext = ST_DRAIN;
        end
      end
      ST_DRAIN: begin
        if (frameN) stateNext = ST_IDLE;
      end
      ST_BUSY: begin
        if (frameN && irdyN) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign devselN = !((state == ST_DATA) || (state == ST_DRAIN));
  assign trdyN   = !((state == ST_DATA) && localReady);
  assign stopN   = !(((state == ST_DATA) && singleOnly) || (state == ST_DRAIN));

  // R2
  devsel_after_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(devselN) |-> $past(!frameN));

  // R3
  trdy_with_devsel_chk: assert property (@(posedge clk) disable iff (!rstN)
    !trdyN |-> !devselN);

  // R7
  stop_no_more_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!irdyN && !trdyN && !stopN && !frameN) |=> (trdyN && !stopN && !devselN));

  // R9
  release_after_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!irdyN && !trdyN && frameN) |=> (trdyN && devselN && stopN));
endmodule

// File: rtl/pciTgtSeq.sv
module pciTgtSeq
  import pciTgtSeqPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LINE_WORDS = 4,
  parameter logic [ADDR_W-1:0] REG_BASE = 32'h0000_1000,
  parameter logic [ADDR_W-1:0] REG_MASK = 32'hFFFF_FF00,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'h0010_0000,
  parameter logic [ADDR_W-1:0] WIN_MASK = 32'hFFF0_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameN,
  input  logic              irdyN,
  input  logic [ADDR_W-1:0] adIn,
  input  logic              localReady,
  output logic              trdyN,
  output logic              devselN,
  output logic              stopN,
  output logic [ADDR_W-1:0] phaseAddr
);
  tgtStrobe_t strobes;
  logic       addrHit;
  logic       singleOnly;

  pciTgtSeqCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .frameN(frameN), .irdyN(irdyN),
    .localReady(localReady), .addrHit(addrHit), .singleOnly(singleOnly),
    .strobes(strobes), .trdyN(trdyN), .devselN(devselN), .stopN(stopN)
  );

  pciTgtSeqPath #(
    .ADDR_W(ADDR_W), .LINE_WORDS(LINE_WORDS),
    .REG_BASE(REG_BASE), .REG_MASK(REG_MASK),
    .WIN_BASE(WIN_BASE), .WIN_MASK(WIN_MASK)
  ) u_path (
    .clk(clk), .rstN(rstN), .adIn(adIn), .strobes(strobes),
    .addrHit(addrHit), .singleOnly(singleOnly), .phaseAddr(phaseAddr)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rstN |=> (trdyN && devselN && stopN));
endmodule

// File: tb/pciTgtSeq_bench.sv
module pciTgtSeq_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameN = 1'b1;
  logic irdyN = 1'b1;
  logic [31:0] adIn = '0;
  logic localReady = 1'b0;
  logic trdyN, devselN, stopN;
  logic [31:0] phaseAddr;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  pciTgtSeq u_pciTgtSeq (
    .clk(clk), .rstN(rstN), .frameN(frameN), .irdyN(irdyN), .adIn(adIn),
    .localReady(localReady), .trdyN(trdyN), .devselN(devselN),
    .stopN(stopN), .phaseAddr(phaseAddr)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !finished) begin
      failures = failures + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected fewer", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (!ok) begin
      failures = failures + 1;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chkIdle(input string tag);
    chk(trdyN == 1'b1, {tag, " trdyN"}, 32'(trdyN), 32'd1);
    chk(devselN == 1'b1, {tag, " devselN"}, 32'(devselN), 32'd1);
    chk(stopN == 1'b1, {tag, " stopN"}, 32'(stopN), 32'd1);
  endtask

  // kind: 0 register region, 1 window, 2 unclaimed
  task automatic runTxn(input logic [31:0] base, input int code, input int nPh, input int seed, input int kind);
    logic [31:0] exp;
    int done;
    int cyc;
    bit single;
    bit ready;
    bit leave;
    single = (kind == 0) || (code == 1) || (code == 3);
    @(negedge clk);
    frameN = 1'b0; irdyN = 1'b1; adIn = base | 32'(code); localReady = 1'b0;
    @(negedge clk);
    irdyN = 1'b0; adIn = '0; frameN = (nPh == 1);
    if (kind == 2) begin
      #1 chk(devselN == 1'b1, "R2 unclaimed devselN", 32'(devselN), 32'd1);
      @(negedge clk);
      #1 chk(devselN == 1'b1, "R2 unclaimed devselN later", 32'(devselN), 32'd1);
      frameN = 1'b1;
      @(negedge clk);
      irdyN = 1'b1;
      return;
    end
    exp = {base[31:2], 2'b00};
    done = 0; cyc = 0; leave = 0;
    while (!leave) begin
      frameN = (done == nPh - 1);
      ready = ((cyc + seed) % 3) != 2;
      localReady = ready;
      #1;
      chk(devselN == 1'b0, "R2 claim devselN", 32'(devselN), 32'd0);
      chk(trdyN == !ready, "R3 trdyN follows localReady", 32'(trdyN), 32'(!ready));
      chk(stopN == !single, single ? "R7/R8 stop on single" : "R7 no stop on burst",
          32'(stopN), 32'(!single));
      if (done == 0) chk(phaseAddr == exp, "R10 first address", phaseAddr, exp);
      else chk(phaseAddr == exp, code == 2 ? "R5 wrap address / R6 hold" : "R4 linear address / R6 hold",
               phaseAddr, exp);
      if (ready) begin
        done++;
        if (code == 2) exp = {exp[31:4], exp[3:2] + 2'd1, 2'b00};
        else exp = exp + 32'd4;
        if (done == nPh || single) leave = 1;
      end
      @(negedge clk);
      cyc++;
    end
    localReady = 1'b0;
    if (done == nPh) begin
      #1 chkIdle("R9 release after last");
      irdyN = 1'b1;
    end else begin
      #1;
      chk(trdyN == 1'b1, "R7 drain trdyN", 32'(trdyN), 32'd1);
      chk(stopN == 1'b0, "R7 drain stopN", 32'(stopN), 32'd0);
      chk(devselN == 1'b0, "R7 drain devselN", 32'(devselN), 32'd0);
      frameN = 1'b1;
      @(negedge clk);
      #1 chkIdle("R7 release after drain");
      irdyN = 1'b1;
    end
  endtask

  initial begin
    logic [31:0] base;
    repeat (3) @(negedge clk);
    #1 chkIdle("R1 in reset");
    rstN = 1'b1;
    @(negedge clk);
    #1 chkIdle("R1 after reset");
    for (int kind = 0; kind < 3; kind++)
      for (int code = 0; code < 4; code++)
        for (int off = 0; off < 4; off++)
          for (int nPh = 1; nPh <= 5; nPh++)
            for (int seed = 0; seed < 3; seed++) begin
              if (kind == 0) base = 32'h0000_1020 + 32'(off * 4);
              else if (kind == 1) base = 32'h0010_0030 + 32'(off * 4);
              else base = 32'h0800_0040 + 32'(off * 4);
              runTxn(base, code, nPh, seed, kind);
            end
    @(negedge clk);
    #1 chkIdle("R9 quiet at end");
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule